// File: doc/BRIEF.md
# Sparse/Dense I/O Window Translator

This block sits between a processor bus and a legacy port bus. Byte, halfword and word accesses that land inside an 8 MB processor address window are claimed, converted to a 16-bit port number and passed on to the port bus. Multi-byte data is byte-swapped in both directions, because the processor and the port devices use opposite byte orders.

Two address mappings exist. The dense mapping uses the low 16 bits of the window offset directly, giving a 64 KB port space. The sparse mapping spreads the ports out so that each 4 KB page of the window holds 32 consecutive ports. A one-bit control register, reached as a port inside the window, selects the mapping while the system runs. A second local port, a cache-invalidate strobe, answers reads with no effect. Every other port is forwarded and acknowledged without fault.

Top module: `iowin_xlate`

## Requirements
- R1: After reset the mapping bit is 0 (dense mapping), and `io_req` and `cpu_ack` are low.
- R2: An access is claimed (`cpu_claim` high) only when `cpu_addr` lies in [0x8000_0000, 0x8080_0000). An unclaimed access never raises `io_req` or `cpu_ack`.
- R3: Port 0x0850 is the mapping register. A write stores only data bit 0. A read returns the stored bit in bit 0 and zeros in bits 31:1. Neither access is forwarded to the port bus.
- R4: With the mapping bit at 0, the port number is window offset bits [15:0].
- R5: With the mapping bit at 1, port bits [4:0] are offset bits [4:0] and port bits [15:5] are offset bits [22:12]. Offset bits [11:5] have no effect.
- R6: Size code 1 (halfword) swaps the two low bytes. Write data goes out as {16'h0, wdata[7:0], wdata[15:8]}. Read data comes back in the same form, built from `io_rdata`.
- R7: Size code 2 (word) reverses all four bytes on write data and on read data. Size code 3 is treated as a word. Size code 0 (byte) passes all 32 data bits unchanged.
- R8: A read of port 0x0814 completes with `cpu_ack`, returns zero and is not forwarded. Any other port is forwarded, and its access completes.
- R9: A write to the mapping register takes effect from the next window access onward.
- R10: `io_req`, together with its port, size, direction and data, stays stable until `io_ack`. `cpu_ack` is a one-cycle pulse, one cycle after `io_ack` is sampled, or one cycle after acceptance for local ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_addr | input | 32 | Processor physical address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| cpu_wdata | input | 32 | Write data in processor byte order |
| cpu_claim | output | 1 | Access falls inside the window |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| io_req | output | 1 | Port bus request, held until `io_ack` |
| io_port | output | 16 | Translated port number |
| io_size | output | 2 | Access size code |
| io_we | output | 1 | Port bus write |
| io_wdata | output | 32 | Swapped write data |
| io_ack | input | 1 | Port bus completion |
| io_rdata | input | 32 | Port bus read data, valid with `io_ack` |

## Verification
The bench sets the mapping register through its own port, and reaches that port by a different window address in each mode. Suppose the design applied the new mode to the write that changes it, or failed to decode the register after translation. The bench would then see the wrong port number on the following access, or see a forwarded access where none is expected. The sparse vectors set offset bits 11:5 to non-zero values and drive both ends of the page and line fields. A design that leaked those bits into the port number, or cut the page field short, would show a wrong `io_port`. The bench also applies asymmetric data patterns for every size code, including code 3, and probes both window edges. A wrong swap, or a window that claims one address too many or too few, would therefore show as a data miscompare or an unexpected claim.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
package iowin_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RESP = 2'd2
   } xst_e;
endpackage

// File: rtl/iowin_decode.sv
`timescale 1ns/1ps
module iowin_decode #(
   parameter int          ADDR_W   = 32,
   parameter logic [31:0] WIN_BASE = 32'h8000_0000,
   parameter int          WIN_LOG2 = 23
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit,
   output logic [WIN_LOG2-1:0] offset
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("window must be smaller than the address space");
      end
   endgenerate

   assign hit    = (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
   assign offset = addr[WIN_LOG2-1:0];
endmodule

// File: rtl/iowin_addr_map.sv
`timescale 1ns/1ps
module iowin_addr_map #(
   parameter int WIN_LOG2  = 23,
   parameter int PORT_W    = 16,
   parameter int LINE_BITS = 5,
   parameter int PAGE_BITS = 12
) (
   input  logic                sparse,
   input  logic [WIN_LOG2-1:0] offset,
   output logic [PORT_W-1:0]   port
);
   localparam int PAGE_FIELD = WIN_LOG2 - PAGE_BITS;

   generate
      if (PAGE_FIELD + LINE_BITS != PORT_W) begin : g_bad_split
         $error("page field plus line field must fill the port width");
      end
      if (PORT_W > WIN_LOG2) begin : g_bad_dense
         $error("dense mapping needs the window to cover the port space");
      end
   endgenerate

   logic [PORT_W-1:0] dense_port;
   logic [PORT_W-1:0] sparse_port;

   assign dense_port  = offset[PORT_W-1:0];
   assign sparse_port = {offset[WIN_LOG2-1:PAGE_BITS], offset[LINE_BITS-1:0]};
   assign port        = sparse ? sparse_port : dense_port;
endmodule

// File: rtl/iowin_lane_swap.sv
`timescale 1ns/1ps
module iowin_lane_swap
   import iowin_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  size_e             size,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] rev;
   logic [DATA_W-1:0] half;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         assign rev[8*i +: 8] = din[8*(NB-1-i) +: 8];
      end
   endgenerate

   assign half = {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]};

   always_comb begin
      case (size)
         SZ_BYTE: dout = din;
         SZ_HALF: dout = half;
         default: dout = rev;
      endcase
   end
endmodule

// File: rtl/iowin_xlate.sv
`timescale 1ns/1ps
module iowin_xlate
   import iowin_pkg::*;
#(
   parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
   parameter int          WIN_LOG2  = 23,
   parameter int          PORT_W    = 16,
   parameter int          LINE_BITS = 5,
   parameter int          PAGE_BITS = 12,
   parameter int          DATA_W    = 32,
   parameter int          MAP_PORT  = 16'h0850,
   parameter int          INV_PORT  = 16'h0814
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_req,
   input  logic [31:0] cpu_addr,
   input  logic        cpu_we,
   input  logic [1:0]  cpu_size,
   input  logic [31:0] cpu_wdata,
   output logic        cpu_claim,
   output logic        cpu_ack,
   output logic [31:0] cpu_rdata,
   output logic        io_req,
   output logic [15:0] io_port,
   output logic [1:0]  io_size,
   output logic        io_we,
   output logic [31:0] io_wdata,
   input  logic        io_ack,
   input  logic [31:0] io_rdata
);
   localparam logic [PORT_W-1:0] MAP_P = PORT_W'(MAP_PORT);
   localparam logic [PORT_W-1:0] INV_P = PORT_W'(INV_PORT);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("data path is fixed at 32 bits");
      end
      if (PORT_W != 16) begin : g_bad_port
         $error("port bus is fixed at 16 bits");
      end
      if ((WIN_BASE % (32'd1 << WIN_LOG2)) != 0) begin : g_bad_base
         $error("window base must be aligned to the window size");
      end
   endgenerate

   logic                hit;
   logic [WIN_LOG2-1:0] offset;
   logic [PORT_W-1:0]   port_x;
   logic [DATA_W-1:0]   wswap;
   logic [DATA_W-1:0]   rswap;
   logic                mode_q;
   xst_e                state;
   logic                is_map;
   logic                is_inv;

   iowin_decode #(.ADDR_W(32), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
      .addr   (cpu_addr),
      .hit    (hit),
      .offset (offset)
   );

   iowin_addr_map #(.WIN_LOG2(WIN_LOG2), .PORT_W(PORT_W),
                    .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)) u_map (
      .sparse (mode_q),
      .offset (offset),
      .port   (port_x)
   );

   iowin_lane_swap #(.DATA_W(DATA_W)) u_wswap (
      .size (size_e'(cpu_size)),
      .din  (cpu_wdata),
      .dout (wswap)
   );

   iowin_lane_swap #(.DATA_W(DATA_W)) u_rswap (
      .size (size_e'(io_size)),
      .din  (io_rdata),
      .dout (rswap)
   );

   assign cpu_claim = cpu_req & hit;
   assign is_map    = (port_x == MAP_P);
   assign is_inv    = (port_x == INV_P) & ~cpu_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= 1'b0;
         cpu_ack   <= 1'b0;
         cpu_rdata <= '0;
         io_req    <= 1'b0;
         io_port   <= '0;
         io_size   <= 2'd0;
         io_we     <= 1'b0;
         io_wdata  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cpu_ack <= 1'b0;
               if (cpu_claim) begin
                  if (is_map || is_inv) begin
                     if (is_map && cpu_we) mode_q <= cpu_wdata[0];
                     cpu_rdata <= (is_map && !cpu_we) ? {31'd0, mode_q} : 32'd0;
                     cpu_ack   <= 1'b1;
                     state     <= ST_RESP;
                  end else begin
                     io_req   <= 1'b1;
                     io_port  <= port_x;
                     io_size  <= cpu_size;
                     io_we    <= cpu_we;
                     io_wdata <= wswap;
                     state    <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (io_ack) begin
                  io_req    <= 1'b0;
                  cpu_rdata <= io_we ? 32'd0 : rswap;
                  cpu_ack   <= 1'b1;
                  state     <= ST_RESP;
               end
            end
            default: begin
               cpu_ack <= 1'b0;
               state   <= ST_IDLE;
            end
         endcase
      end
   end

   // R2
   no_claim_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cpu_req && !hit) |=> (!io_req && !cpu_ack));

   // R3
   map_port_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cpu_claim && is_map) |=> (!io_req && cpu_ack));

   // R9
   mode_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> cpu_ack);

   // R10
   io_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_ack) |=> (io_req && $stable(io_port) && $stable(io_wdata)
                               && $stable(io_size) && $stable(io_we)));

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R10
   ack_not_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> !cpu_ack);
endmodule

// File: tb/sim_iowin_xlate.sv
`timescale 1ns/1ps
module sim_iowin_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_claim;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        io_req;
   logic [15:0] io_port;
   logic [1:0]  io_size;
   logic        io_we;
   logic [31:0] io_wdata;
   logic        io_ack = 1'b0;
   logic [31:0] io_rdata = '0;

   iowin_xlate u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_claim(cpu_claim), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .io_req(io_req), .io_port(io_port), .io_size(io_size), .io_we(io_we),
      .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
   );

   always #2.5 clk = ~clk;

   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   int          io_cnt = 0;
   logic [15:0] seen_port;
   logic [1:0]  seen_size;
   logic        seen_we;
   logic [31:0] seen_wdata;
   logic [31:0] dev_rdata = '0;

   // port device model: acknowledges each request one cycle after it appears
   always @(negedge clk) begin
      if (io_req && !io_ack) begin
         seen_port  = io_port;
         seen_size  = io_size;
         seen_we    = io_we;
         seen_wdata = io_wdata;
         io_cnt     = io_cnt + 1;
         io_rdata   = dev_rdata;
         io_ack     = 1'b1;
      end else begin
         io_ack = 1'b0;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic acc(input logic [31:0] a, input logic we, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output bit acked, output bit claimed);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
      #1 claimed = cpu_claim;
      acked = 1'b0;
      rd = '0;
      for (int i = 0; i < 8 && !acked; i++) begin
         @(negedge clk);
         if (cpu_ack) begin
            acked = 1'b1;
            rd = cpu_rdata;
         end
      end
      cpu_req = 1'b0;
   endtask

   typedef struct packed {
      logic        mode;
      logic [31:0] addr;
      logic [1:0]  sz;
      logic        we;
      logic [31:0] wd;
      logic [31:0] dev;
      logic [15:0] port;
      logic [31:0] expv;
   } vec_t;

   localparam vec_t VECS [8] = '{
      // R4 R7 dense byte write
      '{1'b0, 32'h8000_0060, 2'd0, 1'b1, 32'hCAFE_00A5, 32'h0, 16'h0060, 32'hCAFE_00A5},
      // R4 R6 dense halfword write
      '{1'b0, 32'h8000_03F8, 2'd1, 1'b1, 32'h0000_1234, 32'h0, 16'h03F8, 32'h0000_3412},
      // R4 R7 dense word read, offset above 64 KB
      '{1'b0, 32'h8012_1CF8, 2'd2, 1'b0, 32'h0, 32'h1122_3344, 16'h1CF8, 32'h4433_2211},
      // R4 R6 dense halfword read
      '{1'b0, 32'h8000_0070, 2'd1, 1'b0, 32'h0, 32'h0000_ABCD, 16'h0070, 32'h0000_CDAB},
      // R5 sparse byte write, all line and ignored bits set
      '{1'b1, 32'h8003_FFFF, 2'd0, 1'b1, 32'h0000_005A, 32'h0, 16'h07FF, 32'h0000_005A},
      // R5 R7 sparse word write, top page
      '{1'b1, 32'h807F_F004, 2'd2, 1'b1, 32'hDEAD_BEEF, 32'h0, 16'hFFE4, 32'hEFBE_ADDE},
      // R5 R6 sparse halfword read, bits 11:5 non-zero
      '{1'b1, 32'h8000_1AA2, 2'd1, 1'b0, 32'h0, 32'h0000_5566, 16'h0022, 32'h0000_6655},
      // R5 R7 sparse byte read
      '{1'b1, 32'h8000_0020, 2'd0, 1'b0, 32'h0, 32'h0000_0077, 16'h0000, 32'h0000_0077}
   };

   localparam logic [31:0] MAP_DENSE  = 32'h8000_0850;
   localparam logic [31:0] MAP_SPARSE = 32'h8004_2010;

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      bit          ak;
      bit          cl;
      int          c0;
      logic        cur_mode;

      // R1 reset state
      #1;
      chk("R1 ack in reset", {31'd0, cpu_ack}, 32'd0);
      chk("R1 io_req in reset", {31'd0, io_req}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ack after reset", {31'd0, cpu_ack}, 32'd0);
      chk("R1 io_req after reset", {31'd0, io_req}, 32'd0);
      c0 = io_cnt;
      acc(MAP_DENSE, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R1 mode reads dense", rd, 32'd0);
      chk("R3 mode read acked", {31'd0, ak}, 32'd1);
      chk("R3 mode read not forwarded", io_cnt - c0, 32'd0);
      cur_mode = 1'b0;

      // vector table
      for (int v = 0; v < 8; v++) begin
         if (VECS[v].mode != cur_mode) begin
            c0 = io_cnt;
            acc(cur_mode ? MAP_SPARSE : MAP_DENSE, 1'b1, 2'd0,
                {31'd0, VECS[v].mode}, rd, ak, cl);
            chk("R3 mode write acked", {31'd0, ak}, 32'd1);
            chk("R3 mode write not forwarded", io_cnt - c0, 32'd0);
            cur_mode = VECS[v].mode;
         end
         dev_rdata = VECS[v].dev;
         c0 = io_cnt;
         acc(VECS[v].addr, VECS[v].we, VECS[v].sz, VECS[v].wd, rd, ak, cl);
         chk("R2 claim in window", {31'd0, cl}, 32'd1);
         chk("R8 forwarded once", io_cnt - c0, 32'd1);
         chk("R10 acked", {31'd0, ak}, 32'd1);
         chk(VECS[v].mode ? "R5 sparse port" : "R4 dense port",
             {16'd0, seen_port}, {16'd0, VECS[v].port});
         chk("R10 io size", {30'd0, seen_size}, {30'd0, VECS[v].sz});
         chk("R10 io dir", {31'd0, seen_we}, {31'd0, VECS[v].we});
         if (VECS[v].we) chk("R6 R7 write lanes", seen_wdata, VECS[v].expv);
         else            chk("R6 R7 read lanes", rd, VECS[v].expv);
      end

      // R9: sparse mode now active; base+0x850 is port 0x0010, forwarded
      dev_rdata = 32'h0000_00EE;
      c0 = io_cnt;
      acc(MAP_DENSE, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R9 sparse alias forwarded", io_cnt - c0, 32'd1);
      chk("R5 R9 sparse alias port", {16'd0, seen_port}, 32'h0000_0010);

      // R3: only bit 0 stored, read back through sparse address
      acc(MAP_SPARSE, 1'b1, 2'd0, 32'hFFFF_FFFF, rd, ak, cl);
      acc(MAP_SPARSE, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R3 stored bit only", rd, 32'd1);
      // R3 R9: write 0 via sparse address, next access dense
      acc(MAP_SPARSE, 1'b1, 2'd0, 32'hFFFF_FFFE, rd, ak, cl);
      c0 = io_cnt;
      acc(MAP_DENSE, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R9 back to dense, local", io_cnt - c0, 32'd0);
      chk("R3 R9 dense readback", rd, 32'd0);

      // R8 invalidate port read
      dev_rdata = 32'h1234_5678;
      c0 = io_cnt;
      acc(32'h8000_0814, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R8 invalidate acked", {31'd0, ak}, 32'd1);
      chk("R8 invalidate data", rd, 32'd0);
      chk("R8 invalidate not forwarded", io_cnt - c0, 32'd0);
      acc(MAP_DENSE, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R8 invalidate no side effect", rd, 32'd0);

      // R7 size code 3 acts as word
      acc(32'h8000_0100, 1'b1, 2'd3, 32'h0102_0304, rd, ak, cl);
      chk("R7 size 3 write lanes", seen_wdata, 32'h0403_0201);

      // R2 window edges
      c0 = io_cnt;
      acc(32'h7FFF_FFFF, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R2 below window claim", {31'd0, cl}, 32'd0);
      chk("R2 below window ack", {31'd0, ak}, 32'd0);
      acc(32'h8080_0000, 1'b1, 2'd2, 32'd1, rd, ak, cl);
      chk("R2 above window claim", {31'd0, cl}, 32'd0);
      chk("R2 above window ack", {31'd0, ak}, 32'd0);
      chk("R2 no forward outside", io_cnt - c0, 32'd0);
      acc(32'h807F_FFFF, 1'b0, 2'd0, 32'd0, rd, ak, cl);
      chk("R2 last byte claimed", {31'd0, cl}, 32'd1);
      chk("R4 last byte dense port", {16'd0, seen_port}, 32'h0000_FFFF);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule